// File: doc/BRIEF.md
# Pointer Register Address Generator

This block turns a data-memory or program-memory access request into a memory address. It also produces the updated pointer value to be written back to the register file. A request names an addressing mode and one of three 16-bit pointers. It may also carry a 6-bit unsigned offset, a 16-bit absolute address, and a store flag. The block reads the current values of the three pointers from its pointer inputs at the moment it takes the request. It then holds the address and the access strobes for the whole access. In the last cycle of the access it pulses a done signal, together with a write-back enable when the mode changes the pointer.

Requests arrive on a valid/ready handshake. The generator takes a request on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from the edge that takes a request until the edge after done. While it is low, `req_valid` is ignored, so the requester must hold its request until it sees ready. A request with an illegal combination is dropped on the edge where it is offered: it makes no access and raises no done. Reading the register file and driving the memory array are left to the surrounding logic.

Top module: `ptr_agu`

## Requirements
- R1: After reset, `req_ready` is 1 and `done`, `wb_en`, `dmem_en`, `pmem_en` and `mem_we` are 0.
- R2: Mode 0 (plain indirect) drives `mem_addr` with the selected pointer (sel 0 = X, 1 = Y, 2 = Z), and `wb_en` stays 0.
- R3: Mode 1 (post-increment) drives `mem_addr` with the old pointer and writes back the old pointer plus one, modulo 2^16 (0xFFFF becomes 0x0000). `wb_sel` names the pointer.
- R4: Mode 2 (pre-decrement) drives `mem_addr` with the pointer minus one and writes back that same value, modulo 2^16 (0x0000 becomes 0xFFFF).
- R5: Mode 3 (displacement) drives `mem_addr` with the pointer plus the zero-extended 6-bit `disp`, modulo 2^16. It is allowed for Y and Z only and never writes back.
- R6: Mode 4 (direct) drives `mem_addr` with `imm_addr`, whatever `ptr_sel` holds, and never writes back.
- R7: A data access (modes 0 to 4) takes DATA_CYC cycles. `dmem_en` is high and `mem_addr` is steady from the cycle after the accepting edge. `done` is high in cycle DATA_CYC, and `req_ready` is low until the edge after done.
- R8: Mode 5 (program read) and mode 6 (program read with post-increment) always use Z. They raise `pmem_en` instead of `dmem_en`, take PMEM_CYC cycles, and only mode 6 writes back Z plus one.
- R9: A request for mode 3 with X, a request for mode 7, or a request for a pointer mode (0 to 3) with sel 3 is dropped. `req_ready` stays 1, and no strobe and no done follow.
- R10: `done` is a single-cycle pulse, and `wb_en` is high only in a cycle where `done` is high.
- R11: `mem_we` follows the request's store flag during a data access and is always 0 during a program read.
- R12: A request offered while the block is busy is ignored. The current access keeps its address and completes, and no extra done follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_mode | input | 3 | Addressing mode, encoded as in R2 to R8 |
| req_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z |
| req_store | input | 1 | 1 = store, 0 = load (data modes) |
| req_disp | input | 6 | Unsigned displacement |
| req_imm | input | 16 | Direct address |
| ptr_x | input | 16 | Current X pointer |
| ptr_y | input | 16 | Current Y pointer |
| ptr_z | input | 16 | Current Z pointer |
| mem_addr | output | 16 | Access address |
| dmem_en | output | 1 | Data memory access in progress |
| pmem_en | output | 1 | Program memory read in progress |
| mem_we | output | 1 | Data memory write |
| done | output | 1 | Last cycle of the access |
| wb_en | output | 1 | Write back the pointer |
| wb_sel | output | 2 | Pointer to write back |
| wb_value | output | 16 | New pointer value |

## Verification
The bench uses the default parameters: 16-bit addresses, a 6-bit displacement, DATA_CYC of 2 and PMEM_CYC of 3. With these values the wrap cases are easy to reach: 0xFFFF incremented, 0x0000 decremented, and a displacement of 63 on a pointer near the top of memory. Both cycle lengths are short enough that every cycle of every access can be checked. Because the two lengths differ, a program read that completed on the data-access schedule would be caught.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    MODE_IND     = 3'd0,
    MODE_POSTINC = 3'd1,
    MODE_PREDEC  = 3'd2,
    MODE_DISP    = 3'd3,
    MODE_DIRECT  = 3'd4,
    MODE_PREAD   = 3'd5,
    MODE_PREADI  = 3'd6,
    MODE_RSVD    = 3'd7
  } agu_mode_e;

  typedef enum logic [1:0] {
    SEL_X    = 2'd0,
    SEL_Y    = 2'd1,
    SEL_Z    = 2'd2,
    SEL_NONE = 2'd3
  } agu_sel_e;
endpackage

// File: rtl/agu_ptr_mux.sv
module agu_ptr_mux #(
  parameter int AW   = 16,
  parameter int NPTR = 3
) (
  input  logic [NPTR*AW-1:0] ptrs,
  input  logic [1:0]         sel,
  output logic [AW-1:0]      ptr
);
  logic [AW-1:0] slot [NPTR];

  for (genvar i = 0; i < NPTR; i++) begin : g_slot
    assign slot[i] = ptrs[i*AW +: AW];
  end

  always_comb begin
    ptr = '0;
    for (int i = 0; i < NPTR; i++) begin
      if (int'(sel) == i) ptr = slot[i];
    end
  end
endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
  import agu_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 6
) (
  input  logic [2:0]    mode,
  input  logic [1:0]    sel,
  input  logic [AW-1:0] ptr,
  input  logic [DW-1:0] disp,
  input  logic [AW-1:0] imm,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] wb_val,
  output logic          wb_flag,
  output logic          is_pmem,
  output logic          legal
);
  localparam int PADW = AW - DW;

  logic [AW-1:0] ptr_inc;
  logic [AW-1:0] ptr_dec;
  logic [AW-1:0] ptr_off;

  assign ptr_inc = ptr + AW'(1);
  assign ptr_dec = ptr - AW'(1);
  assign ptr_off = ptr + {{PADW{1'b0}}, disp};

  always_comb begin
    addr    = ptr;
    wb_val  = ptr;
    wb_flag = 1'b0;
    is_pmem = 1'b0;
    legal   = (sel != SEL_NONE);
    unique case (agu_mode_e'(mode))
      MODE_IND: ;
      MODE_POSTINC: begin
        wb_val  = ptr_inc;
        wb_flag = 1'b1;
      end
      MODE_PREDEC: begin
        addr    = ptr_dec;
        wb_val  = ptr_dec;
        wb_flag = 1'b1;
      end
      MODE_DISP: begin
        addr  = ptr_off;
        legal = (sel == SEL_Y) || (sel == SEL_Z);
      end
      MODE_DIRECT: begin
        addr  = imm;
        legal = 1'b1;
      end
      MODE_PREAD: begin
        is_pmem = 1'b1;
        legal   = 1'b1;
      end
      MODE_PREADI: begin
        is_pmem = 1'b1;
        wb_val  = ptr_inc;
        wb_flag = 1'b1;
        legal   = 1'b1;
      end
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/agu_seq.sv
module agu_seq #(
  parameter int DATA_CYC = 2,
  parameter int PMEM_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic long_op,
  output logic busy,
  output logic last
);
  localparam int MAXC = (DATA_CYC > PMEM_CYC) ? DATA_CYC : PMEM_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] len_q;

  assign last = busy && (cnt == len_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      len_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt   <= CW'(1);
      len_q <= long_op ? CW'(PMEM_CYC) : CW'(DATA_CYC);
    end else if (busy) begin
      if (last) busy <= 1'b0;
      else      cnt  <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
  import agu_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 6,
  parameter int DATA_CYC = 2,
  parameter int PMEM_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_mode,
  input  logic [1:0]    req_sel,
  input  logic          req_store,
  input  logic [DW-1:0] req_disp,
  input  logic [AW-1:0] req_imm,
  input  logic [AW-1:0] ptr_x,
  input  logic [AW-1:0] ptr_y,
  input  logic [AW-1:0] ptr_z,
  output logic [AW-1:0] mem_addr,
  output logic          dmem_en,
  output logic          pmem_en,
  output logic          mem_we,
  output logic          done,
  output logic          wb_en,
  output logic [1:0]    wb_sel,
  output logic [AW-1:0] wb_value
);
  localparam int NPTR = 3;

  logic          pmem_mode;
  logic [1:0]    eff_sel;
  logic [AW-1:0] cur_ptr;
  logic [AW-1:0] c_addr;
  logic [AW-1:0] c_wb;
  logic          c_wbf;
  logic          c_pmem;
  logic          c_legal;
  logic          start;
  logic          busy;
  logic          last;

  logic          pmem_q;
  logic          store_q;
  logic          wbf_q;

  assign pmem_mode = (req_mode == MODE_PREAD) || (req_mode == MODE_PREADI);
  assign eff_sel   = pmem_mode ? SEL_Z : req_sel;

  agu_ptr_mux #(.AW(AW), .NPTR(NPTR)) u_mux (
    .ptrs ({ptr_z, ptr_y, ptr_x}),
    .sel  (eff_sel),
    .ptr  (cur_ptr)
  );

  agu_addr_calc #(.AW(AW), .DW(DW)) u_calc (
    .mode    (req_mode),
    .sel     (eff_sel),
    .ptr     (cur_ptr),
    .disp    (req_disp),
    .imm     (req_imm),
    .addr    (c_addr),
    .wb_val  (c_wb),
    .wb_flag (c_wbf),
    .is_pmem (c_pmem),
    .legal   (c_legal)
  );

  assign req_ready = !busy;
  assign start     = req_valid && req_ready && c_legal;

  agu_seq #(.DATA_CYC(DATA_CYC), .PMEM_CYC(PMEM_CYC)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .long_op (c_pmem),
    .busy    (busy),
    .last    (last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr <= '0;
      wb_value <= '0;
      wb_sel   <= SEL_X;
      wbf_q    <= 1'b0;
      pmem_q   <= 1'b0;
      store_q  <= 1'b0;
    end else if (start) begin
      mem_addr <= c_addr;
      wb_value <= c_wb;
      wb_sel   <= eff_sel;
      wbf_q    <= c_wbf;
      pmem_q   <= c_pmem;
      store_q  <= req_store && !c_pmem;
    end
  end

  assign dmem_en = busy && !pmem_q;
  assign pmem_en = busy && pmem_q;
  assign mem_we  = dmem_en && store_q;
  assign done    = last;
  assign wb_en   = last && wbf_q;
endmodule

// File: rtl/ptr_agu_checker.sv
module ptr_agu_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [2:0]    req_mode,
  input logic [1:0]    req_sel,
  input logic [AW-1:0] mem_addr,
  input logic          dmem_en,
  input logic          pmem_en,
  input logic          mem_we,
  input logic          done,
  input logic          wb_en
);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_wb_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);

  assert_ready_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (dmem_en || pmem_en));

  assert_addr_steady_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((dmem_en || pmem_en) && !done) |=> $stable(mem_addr));

  assert_no_we_pmem_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pmem_en |-> !mem_we);

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_en && pmem_en));

  assert_drop_x_disp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mode == 3'd3 && req_sel == 2'd0) |=> req_ready);

  assert_drop_rsvd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mode == 3'd7) |=> req_ready);
endmodule

bind ptr_agu ptr_agu_checker #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_mode  (req_mode),
  .req_sel   (req_sel),
  .mem_addr  (mem_addr),
  .dmem_en   (dmem_en),
  .pmem_en   (pmem_en),
  .mem_we    (mem_we),
  .done      (done),
  .wb_en     (wb_en)
);

// File: tb/ptr_agu_bench.sv
`timescale 1ns/1ps
module ptr_agu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_mode = '0;
  logic [1:0]  req_sel = '0;
  logic        req_store = 1'b0;
  logic [5:0]  req_disp = '0;
  logic [15:0] req_imm = '0;
  logic [15:0] ptr_x = '0, ptr_y = '0, ptr_z = '0;
  logic [15:0] mem_addr;
  logic        dmem_en, pmem_en, mem_we, done, wb_en;
  logic [1:0]  wb_sel;
  logic [15:0] wb_value;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ptr_agu u_ptr_agu (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_sel(req_sel), .req_store(req_store),
    .req_disp(req_disp), .req_imm(req_imm), .ptr_x(ptr_x), .ptr_y(ptr_y),
    .ptr_z(ptr_z), .mem_addr(mem_addr), .dmem_en(dmem_en), .pmem_en(pmem_en),
    .mem_we(mem_we), .done(done), .wb_en(wb_en), .wb_sel(wb_sel),
    .wb_value(wb_value)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Offers one request, checks every cycle of the access and the idle cycle after.
  task automatic run_req(input logic [2:0] mode, input logic [1:0] sel,
                         input logic st, input logic [5:0] q, input logic [15:0] k,
                         input logic [15:0] exp_addr, input logic exp_wbf,
                         input logic [15:0] exp_wb, input logic [1:0] exp_sel,
                         input int len, input logic is_p, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_mode = mode; req_sel = sel; req_store = st;
    req_disp = q; req_imm = k;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 1; c <= len; c++) begin
      check(mem_addr == exp_addr, {tag, " addr"}, mem_addr, exp_addr);
      check(dmem_en == !is_p && pmem_en == is_p, {"R8 strobe ", tag},
            {dmem_en, pmem_en}, {!is_p, is_p});
      check(mem_we == (st && !is_p), {"R11 we ", tag}, mem_we, st && !is_p);
      check(req_ready == 1'b0, {"R7 ready busy ", tag}, req_ready, 0);
      check(done == (c == len), {"R7 done timing ", tag}, done, c == len);
      check(wb_en == (exp_wbf && c == len), {"R10 wb_en ", tag}, wb_en,
            exp_wbf && c == len);
      if (c == len && exp_wbf) begin
        check(wb_value == exp_wb, {tag, " wb_value"}, wb_value, exp_wb);
        check(wb_sel == exp_sel, {tag, " wb_sel"}, wb_sel, exp_sel);
      end
      @(negedge clk);
    end
    check(req_ready && !done && !dmem_en && !pmem_en, {"R7 idle after ", tag},
          {req_ready, done, dmem_en, pmem_en}, 4'b1000);
  endtask

  task automatic t_reset;
    check(req_ready == 1 && done == 0 && wb_en == 0 && dmem_en == 0 &&
          pmem_en == 0 && mem_we == 0, "R1 reset state",
          {req_ready, done, wb_en, dmem_en, pmem_en, mem_we}, 6'b100000);
  endtask

  task automatic t_indirect;
    ptr_x = 16'h1234; ptr_y = 16'h0100; ptr_z = 16'hBEEF;
    run_req(3'd0, 2'd0, 1'b0, 6'd0, 16'h0, 16'h1234, 0, 16'h0, 2'd0, 2, 0, "R2 X");
    run_req(3'd0, 2'd2, 1'b1, 6'd0, 16'h0, 16'hBEEF, 0, 16'h0, 2'd2, 2, 0, "R2 Z store");
  endtask

  task automatic t_postinc;
    ptr_y = 16'h0FFF;
    run_req(3'd1, 2'd1, 1'b0, 6'd0, 16'h0, 16'h0FFF, 1, 16'h1000, 2'd1, 2, 0, "R3 Y");
    ptr_x = 16'hFFFF;
    run_req(3'd1, 2'd0, 1'b1, 6'd0, 16'h0, 16'hFFFF, 1, 16'h0000, 2'd0, 2, 0, "R3 wrap");
  endtask

  task automatic t_predec;
    ptr_z = 16'h2000;
    run_req(3'd2, 2'd2, 1'b0, 6'd0, 16'h0, 16'h1FFF, 1, 16'h1FFF, 2'd2, 2, 0, "R4 Z");
    ptr_x = 16'h0000;
    run_req(3'd2, 2'd0, 1'b1, 6'd0, 16'h0, 16'hFFFF, 1, 16'hFFFF, 2'd0, 2, 0, "R4 wrap");
  endtask

  task automatic t_disp;
    ptr_y = 16'h0100;
    run_req(3'd3, 2'd1, 1'b0, 6'd63, 16'h0, 16'h013F, 0, 16'h0, 2'd1, 2, 0, "R5 Y q63");
    ptr_z = 16'hFFF0;
    run_req(3'd3, 2'd2, 1'b1, 6'd32, 16'h0, 16'h0010, 0, 16'h0, 2'd2, 2, 0, "R5 Z wrap");
  endtask

  task automatic t_direct;
    run_req(3'd4, 2'd3, 1'b1, 6'd5, 16'hA55A, 16'hA55A, 0, 16'h0, 2'd0, 2, 0, "R6 k");
  endtask

  task automatic t_pmem;
    ptr_x = 16'h1111; ptr_z = 16'h4000;
    run_req(3'd5, 2'd0, 1'b1, 6'd0, 16'h0, 16'h4000, 0, 16'h0, 2'd2, 3, 1, "R8 read");
    ptr_z = 16'hFFFF;
    run_req(3'd6, 2'd1, 1'b0, 6'd0, 16'h0, 16'hFFFF, 1, 16'h0000, 2'd2, 3, 1, "R8 read inc");
  endtask

  task automatic drop_one(input logic [2:0] mode, input logic [1:0] sel,
                          input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_mode = mode; req_sel = sel;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < 3; c++) begin
      check(req_ready && !dmem_en && !pmem_en && !done, {"R9 drop ", tag},
            {req_ready, dmem_en, pmem_en, done}, 4'b1000);
      @(negedge clk);
    end
  endtask

  task automatic t_illegal;
    drop_one(3'd3, 2'd0, "disp X");
    drop_one(3'd7, 2'd1, "mode7");
    drop_one(3'd1, 2'd3, "sel3");
  endtask

  task automatic t_busy_ignore;
    ptr_x = 16'h0042; ptr_y = 16'h7777;
    @(negedge clk);
    req_valid = 1'b1; req_mode = 3'd1; req_sel = 2'd0; req_store = 1'b0;
    @(negedge clk);
    req_mode = 3'd0; req_sel = 2'd1;
    check(mem_addr == 16'h0042, "R12 busy addr c1", mem_addr, 16'h0042);
    @(negedge clk);
    req_valid = 1'b0;
    check(done && mem_addr == 16'h0042 && wb_value == 16'h0043,
          "R12 busy done", {done, mem_addr, wb_value}, {1'b1, 16'h0042, 16'h0043});
    @(negedge clk);
    check(!done && !dmem_en && req_ready, "R12 no second access",
          {done, dmem_en, req_ready}, 3'b001);
    @(negedge clk);
    check(!done && !dmem_en, "R10 no extra done", {done, dmem_en}, 2'b00);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_indirect();
    t_postinc();
    t_predec();
    t_disp();
    t_direct();
    t_pmem();
    t_illegal();
    t_busy_ignore();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule